// File: doc/BRIEF.md
# ECC Error Capture Log

This block sits beside the ECC checker of one DRAM controller channel and keeps a diagnostic snapshot of the read errors it reports. Every read burst carries four quadwords. Each quadword reports three things: a correctable (single-bit) flag, an uncorrectable (multi-bit) flag and an 8-bit syndrome. The burst also carries the rank, bank, row and column address of the access. The block compresses all of this into one 64-bit read-only log word. That word holds the two status flags, the syndrome and the address of the error that counts most.

After software clears the flags, the first error to arrive is logged and the fields are then locked. An uncorrectable error can still overwrite a log that holds a correctable error, but the reverse never happens. Within a burst, the syndrome comes from the quadword with the highest priority. Every uncorrectable quadword outranks every correctable one, and among quadwords of the same type the lower index wins.

The error inputs form a flow-through stream that is qualified only by `rd_valid`. There is no back-pressure: the block takes a beat on every cycle that `rd_valid` is high, so it never stalls the read path, and it has no ready output. The clear inputs are plain control strobes. They come from the separate error status register when software clears the matching bit there.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, `err_log` reads all zeros.
- R2: Layout of the log word:
  - Column is in bits 63:48, row in 47:32, bank in 31:29 and rank in 28:27.
  - Syndrome is in bits 23:16.
  - The uncorrectable flag is bit 1 and the correctable flag is bit 0.
  - Bits 26:24 and 15:2 always read zero.
  - The rank value is carried unchanged: 2'b10 means rank 2, the first rank of the second DIMM.
- R3: A beat with `rd_valid` high and any correctable flag, arriving while both status flags are clear, sets bit 0 and captures its address and syndrome one cycle later.
- R4: While the correctable flag is set (and no uncorrectable flag is set), further correctable-only beats leave the address and syndrome unchanged.
- R5: An uncorrectable beat arriving while only the correctable flag is set overwrites the address and syndrome and sets bit 1. Bit 0 stays set.
- R6: While the uncorrectable flag is set, beats of either type leave every logged field unchanged. A correctable beat may still set bit 0.
- R7: Within one burst, the syndrome is chosen in this order: uncorrectable on quadword 0, 1, 2, 3, then correctable on quadword 0, 1, 2, 3.
- R8: Each status bit clears only through its own clear input. The address and syndrome keep their values when flags are cleared. The fields unlock only once both flags are clear, so clearing only bit 0 while bit 1 is set keeps the fields locked.
- R9: When a clear and a new error of the cleared severity land in the same cycle, the new error is logged and its flag remains set.
- R10: Error inputs are ignored on cycles where `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read beat valid; qualifies all error inputs |
| qw_cerr | input | 4 | Correctable-error flag per quadword (bit i = quadword i) |
| qw_merr | input | 4 | Uncorrectable-error flag per quadword |
| qw_synd | input | 32 | Syndromes; bits 8i+7:8i belong to quadword i |
| addr_rank | input | 2 | Rank of the burst |
| addr_bank | input | 3 | Bank of the burst |
| addr_row | input | 16 | Row of the burst |
| addr_col | input | 16 | Column of the burst |
| clr_cerr | input | 1 | Software cleared the correctable status bit |
| clr_merr | input | 1 | Software cleared the uncorrectable status bit |
| err_log | output | 64 | Read-only log word |

## Verification
Two events can fall in the same cycle: a clear strobe from the status register and a new error beat from the ECC checker. The bench provokes this by raising `clr_cerr` together with a correctable beat that carries a fresh address. It also raises both clears together with an uncorrectable beat. It then judges the log word one cycle later: it must hold the new address and syndrome, and the matching flag must still be set. A second collision is an uncorrectable and a correctable error inside the same burst. The bench judges it by the syndrome that is captured and by both flags being set.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int LOG_W   = 64;
  localparam int COL_W   = 16;
  localparam int ROW_W   = 16;
  localparam int BANK_W  = 3;
  localparam int RANK_W  = 2;
  localparam int SYN_W   = 8;

  // bit positions that readers of the log decode
  localparam int COL_LSB  = 48;
  localparam int ROW_LSB  = 32;
  localparam int BANK_LSB = 29;
  localparam int RANK_LSB = 27;
  localparam int SYN_LSB  = 16;
  localparam int MFLG_BIT = 1;
  localparam int CFLG_BIT = 0;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
  } burst_addr_t;

  typedef struct packed {
    burst_addr_t       addr;
    logic [SYN_W-1:0]  synd;
  } log_fields_t;
endpackage

// File: rtl/ecc_qw_prio.sv
module ecc_qw_prio #(
  parameter int NUM_QW = 4,
  parameter int SYND_W = 8
) (
  input  logic                     beat_vld,
  input  logic [NUM_QW-1:0]        cerr,
  input  logic [NUM_QW-1:0]        merr,
  input  logic [NUM_QW*SYND_W-1:0] synd_flat,
  output logic                     hit_merr,
  output logic                     hit_cerr,
  output logic [SYND_W-1:0]        win_synd
);
  logic [SYND_W-1:0] synd_arr [NUM_QW];
  logic [SYND_W-1:0] c_pick;
  logic [SYND_W-1:0] m_pick;

  for (genvar g = 0; g < NUM_QW; g++) begin : g_unpack
    assign synd_arr[g] = synd_flat[g*SYND_W +: SYND_W];
  end

  // scan high to low so the lowest quadword index ends up selected
  always_comb begin
    c_pick = '0;
    m_pick = '0;
    for (int i = NUM_QW-1; i >= 0; i--) begin
      if (cerr[i]) c_pick = synd_arr[i];
      if (merr[i]) m_pick = synd_arr[i];
    end
  end

  assign hit_merr = beat_vld && (|merr);
  assign hit_cerr = beat_vld && (|cerr);
  assign win_synd = (|merr) ? m_pick : c_pick;

  always_comb begin
    if (hit_merr && merr[0]) assert_qw0_wins_R7: assert (win_synd == synd_arr[0]);
  end
endmodule

// File: rtl/ecc_lock_ctrl.sv
module ecc_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_merr,
  input  logic hit_cerr,
  input  logic clr_cerr,
  input  logic clr_merr,
  output logic m_flag,
  output logic c_flag,
  output logic take
);
  logic m_hold;
  logic c_hold;

  // lock state as it stands once this cycle's clears are applied
  assign m_hold = m_flag && !clr_merr;
  assign c_hold = c_flag && !clr_cerr;

  always_comb begin
    take = 1'b0;
    if (hit_merr && !m_hold)                       take = 1'b1;
    else if (hit_cerr && !hit_merr && !m_hold && !c_hold) take = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_flag <= 1'b0;
      c_flag <= 1'b0;
    end else begin
      m_flag <= m_hold || hit_merr;
      c_flag <= c_hold || hit_cerr;
    end
  end

  assert_merr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_flag && !clr_merr) |=> m_flag);
  assert_cerr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_flag && !clr_cerr) |=> c_flag);
  assert_merr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_merr |=> m_flag);
  assert_cerr_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cerr |=> c_flag);
endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store
  import ecc_log_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  log_fields_t fresh,
  output log_fields_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (take) held <= fresh;
  end
endmodule

// File: rtl/ecc_log_pack.sv
module ecc_log_pack
  import ecc_log_pkg::*;
(
  input  log_fields_t       fld,
  input  logic              m_flag,
  input  logic              c_flag,
  output logic [LOG_W-1:0]  word
);
  always_comb begin
    word = '0;
    word[COL_LSB  +: COL_W]  = fld.addr.col;
    word[ROW_LSB  +: ROW_W]  = fld.addr.row;
    word[BANK_LSB +: BANK_W] = fld.addr.bank;
    word[RANK_LSB +: RANK_W] = fld.addr.rank;
    word[SYN_LSB  +: SYN_W]  = fld.synd;
    word[MFLG_BIT]           = m_flag;
    word[CFLG_BIT]           = c_flag;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int NUM_QW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  input  logic [NUM_QW-1:0]       qw_cerr,
  input  logic [NUM_QW-1:0]       qw_merr,
  input  logic [NUM_QW*SYN_W-1:0] qw_synd,
  input  logic [RANK_W-1:0]       addr_rank,
  input  logic [BANK_W-1:0]       addr_bank,
  input  logic [ROW_W-1:0]        addr_row,
  input  logic [COL_W-1:0]        addr_col,
  input  logic                    clr_cerr,
  input  logic                    clr_merr,
  output logic [LOG_W-1:0]        err_log
);
  logic        hit_merr;
  logic        hit_cerr;
  logic [SYN_W-1:0] win_synd;
  logic        m_flag;
  logic        c_flag;
  logic        take;
  log_fields_t fresh;
  log_fields_t held;

  ecc_qw_prio #(.NUM_QW(NUM_QW), .SYND_W(SYN_W)) u_prio (
    .beat_vld (rd_valid),
    .cerr     (qw_cerr),
    .merr     (qw_merr),
    .synd_flat(qw_synd),
    .hit_merr (hit_merr),
    .hit_cerr (hit_cerr),
    .win_synd (win_synd)
  );

  ecc_lock_ctrl u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_merr(hit_merr),
    .hit_cerr(hit_cerr),
    .clr_cerr(clr_cerr),
    .clr_merr(clr_merr),
    .m_flag  (m_flag),
    .c_flag  (c_flag),
    .take    (take)
  );

  assign fresh.addr.col  = addr_col;
  assign fresh.addr.row  = addr_row;
  assign fresh.addr.bank = addr_bank;
  assign fresh.addr.rank = addr_rank;
  assign fresh.synd      = win_synd;

  ecc_log_store u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .fresh(fresh),
    .held (held)
  );

  ecc_log_pack u_pack (
    .fld   (held),
    .m_flag(m_flag),
    .c_flag(c_flag),
    .word  (err_log)
  );

  assert_merr_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_log[MFLG_BIT] && !clr_merr) |=> $stable(err_log[LOG_W-1:SYN_LSB]));
  assert_cerr_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_log[CFLG_BIT] && !clr_cerr && !(rd_valid && |qw_merr))
      |=> $stable(err_log[LOG_W-1:SYN_LSB]));
  assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !clr_cerr && !clr_merr) |=> $stable(err_log));
  assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && |qw_cerr && !err_log[MFLG_BIT] && !err_log[CFLG_BIT])
      |=> (err_log[COL_LSB +: COL_W] == $past(addr_col)));
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [3:0]  qw_cerr = '0;
  logic [3:0]  qw_merr = '0;
  logic [31:0] qw_synd = '0;
  logic [1:0]  addr_rank = '0;
  logic [2:0]  addr_bank = '0;
  logic [15:0] addr_row = '0;
  logic [15:0] addr_col = '0;
  logic        clr_cerr = 1'b0;
  logic        clr_merr = 1'b0;
  logic [63:0] err_log;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_log;

  always #4 clk = ~clk;

  ecc_err_log u0 (.*);

  function automatic logic [63:0] mk(input logic [15:0] col, input logic [15:0] row,
      input logic [2:0] bank, input logic [1:0] rank, input logic [7:0] syn,
      input logic m, input logic c);
    mk = {col, row, bank, rank, 3'b000, syn, 14'd0, m, c};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic beat(input logic v, input logic [3:0] c, input logic [3:0] m,
      input logic [31:0] s, input logic [15:0] col, input logic [15:0] row,
      input logic [2:0] bank, input logic [1:0] rank, input logic cc, input logic cm);
    @(negedge clk);
    rd_valid = v; qw_cerr = c; qw_merr = m; qw_synd = s;
    addr_col = col; addr_row = row; addr_bank = bank; addr_rank = rank;
    clr_cerr = cc; clr_merr = cm;
    @(posedge clk); #1;
    rd_valid = 0; qw_cerr = 0; qw_merr = 0; clr_cerr = 0; clr_merr = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", err_log, 64'd0);
  endtask

  task automatic t_first_cerr;
    beat(1, 4'b0100, 4'b0000, 32'h005A_0000, 16'h1234, 16'hBEEF, 3'd5, 2'd2, 0, 0);
    exp_log = mk(16'h1234, 16'hBEEF, 3'd5, 2'd2, 8'h5A, 0, 1);
    chk("R3 first correctable capture", err_log, exp_log);
    chk("R2 rank 2 at bits 28:27", {62'd0, err_log[28:27]}, 64'd2);
    chk("R2 reserved bits zero", {err_log[26:24], err_log[15:2]}, 64'd0);
  endtask

  task automatic t_cerr_lock;
    beat(1, 4'b0001, 4'b0000, 32'h0000_0077, 16'h1111, 16'h2222, 3'd1, 2'd1, 0, 0);
    chk("R4 later correctable ignored", err_log, exp_log);
  endtask

  task automatic t_merr_over;
    beat(1, 4'b0000, 4'b1000, 32'hC300_0000, 16'hAAAA, 16'h5555, 3'd3, 2'd3, 0, 0);
    exp_log = mk(16'hAAAA, 16'h5555, 3'd3, 2'd3, 8'hC3, 1, 1);
    chk("R5 uncorrectable overwrites", err_log, exp_log);
  endtask

  task automatic t_merr_lock;
    beat(1, 4'b0011, 4'b0001, 32'h0000_1199, 16'h0F0F, 16'hF0F0, 3'd7, 2'd0, 0, 0);
    chk("R6 locked by uncorrectable", err_log, exp_log);
  endtask

  task automatic t_clear_c_only;
    beat(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    exp_log[0] = 1'b0;
    chk("R8 clear correctable only", err_log, exp_log);
    beat(1, 4'b0010, 4'b0000, 32'h0000_4400, 16'h7777, 16'h8888, 3'd2, 2'd1, 0, 0);
    exp_log[0] = 1'b1;
    chk("R8 fields stay locked while bit1 set", err_log, exp_log);
  endtask

  task automatic t_clear_both;
    beat(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    exp_log[1:0] = 2'b00;
    chk("R8 clear both keeps fields", err_log, exp_log);
    beat(1, 4'b1000, 4'b0000, 32'h6600_0000, 16'h0101, 16'h0202, 3'd4, 2'd0, 0, 0);
    exp_log = mk(16'h0101, 16'h0202, 3'd4, 2'd0, 8'h66, 0, 1);
    chk("R8 unlocked after both clear", err_log, exp_log);
  endtask

  task automatic t_burst_prio;
    beat(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    beat(1, 4'b0001, 4'b1010, 32'h44_33_22_11, 16'h3030, 16'h4040, 3'd6, 2'd1, 0, 0);
    exp_log = mk(16'h3030, 16'h4040, 3'd6, 2'd1, 8'h22, 1, 1);
    chk("R7 uncorrectable qw1 beats correctable qw0", err_log, exp_log);
    beat(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    beat(1, 4'b1110, 4'b0000, 32'hDD_CC_BB_AA, 16'h5050, 16'h6060, 3'd0, 2'd3, 0, 0);
    exp_log = mk(16'h5050, 16'h6060, 3'd0, 2'd3, 8'hBB, 0, 1);
    chk("R7 lowest correctable quadword wins", err_log, exp_log);
  endtask

  task automatic t_invalid;
    beat(0, 4'b1111, 4'b1111, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 3'd7, 2'd3, 0, 0);
    chk("R10 error inputs ignored without valid", err_log, exp_log);
  endtask

  task automatic t_collide;
    beat(1, 4'b0001, 4'b0000, 32'h0000_0012, 16'h9A9A, 16'hB1B1, 3'd2, 2'd2, 1, 0);
    exp_log = mk(16'h9A9A, 16'hB1B1, 3'd2, 2'd2, 8'h12, 0, 1);
    chk("R9 clear and correctable same cycle", err_log, exp_log);
    beat(1, 4'b0000, 4'b0001, 32'h0000_00E1, 16'hC0DE, 16'hFACE, 3'd1, 2'd0, 0, 0);
    beat(1, 4'b0000, 4'b0100, 32'h0034_0000, 16'h1357, 16'h2468, 3'd5, 2'd1, 1, 1);
    exp_log = mk(16'h1357, 16'h2468, 3'd5, 2'd1, 8'h34, 1, 0);
    chk("R9 clear and uncorrectable same cycle", err_log, exp_log);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 value after reset release", err_log, 64'd0);
    t_first_cerr();
    t_cerr_lock();
    t_merr_over();
    t_merr_lock();
    t_clear_c_only();
    t_clear_both();
    t_burst_prio();
    t_invalid();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule